// File: doc/BRIEF.md
# Indexed Colour Palette Port

This block gives the processor access to a 64-byte colour palette through two bus registers. An index register selects the byte. A data register reads or writes the selected byte. When the top bit of the index register is set, each data write moves the index on by one, so software can fill the whole palette with a burst of data writes. A chip uses two instances, one for background colours and one for sprite colours.

Each data write raises a one-cycle notification that carries the palette slot just written, so the video pipeline can refresh any converted colour it keeps. A second read port serves the pixel renderer. It is combinational and independent of the processor's index. A colour-capable enable gates the processor side: while it is low, both registers read as all ones and writes have no effect.

Top module: `pal_port`

## Requirements
- R1: After reset the index register holds 0x00, so it reads 0x40, and the change notification is low.
- R2: Reading the index register (regSel = 0) returns the last value written to it with bit 6 forced to 1. Bits 5:0 are the slot address and bit 7 is the auto-advance flag.
- R3: A data-register write (regSel = 1, wrEn = 1) stores wrData at the slot given by index bits 5:0. A data-register read returns the byte held at that slot.
- R4: In the cycle after a data write, chgValid is high for exactly one cycle and chgIndex carries the slot that was written.
- R5: After a data write with index bit 7 set, index bits 5:0 increase by one and bit 7 stays set.
- R6: After a data write with index bit 7 clear, the index register is unchanged.
- R7: The auto-advance wraps from slot 0x3F to slot 0x00 without changing bits 7:6 of the index register.
- R8: While colorEn is low, reads of either register return 0xFF. Writes to either register change neither the index nor the palette, and they raise no notification.
- R9: pixData shows the palette byte at pixIndex in the same cycle, and reading through this port never changes the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colorEn | input | 1 | Colour-capable enable for the processor side |
| regSel | input | 1 | Register select: 0 = index, 1 = data |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 8 | Write data |
| cpuRdData | output | 8 | Read data of the selected register (combinational) |
| chgValid | output | 1 | One-cycle palette-changed strobe |
| chgIndex | output | 6 | Slot that was written, valid with chgValid |
| pixIndex | input | 6 | Renderer read address |
| pixData | output | 8 | Renderer read data (combinational) |

## Verification
The wrap at the top of the palette is the hardest condition to reach from the ports. It only happens after a run of auto-advancing data writes that starts close to slot 0x3F. The bench seeds the index near the top with bit 7 set, then writes across the boundary and checks the index after every write. A second hard case is a write made while the enable is low. The only way to see that it did nothing is to raise the enable again and read back both the index and the targeted slot, so the bench does exactly that.

// File: rtl/pal_port_pkg.sv
package pal_port_pkg;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic idxWr;    // load the index register
    logic dataWr;   // store a palette byte and notify
    logic bump;     // advance the slot address after the store
    logic rdData;   // read mux picks the palette byte
    logic rdBlank;  // read mux returns all ones
  } palCtrl_t;

endpackage

// File: rtl/pal_port_ctrl.sv
module pal_port_ctrl
  import pal_port_pkg::*;
(
  input  logic     colorEn,
  input  logic     wrEn,
  input  logic     regSel,
  input  logic     autoInc,
  output palCtrl_t ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.rdBlank = !colorEn;
    ctrl.rdData  = regSel;
    if (colorEn && wrEn) begin
      ctrl.idxWr  = !regSel;
      ctrl.dataWr = regSel;
      ctrl.bump   = regSel && autoInc;
    end
  end

endmodule

// File: rtl/pal_port_dp.sv
module pal_port_dp
  import pal_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  palCtrl_t          ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] pixIndex,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              chgValid,
  output logic [ADDR_W-1:0] chgIndex,
  output logic [DATA_W-1:0] pixData,
  output logic [DATA_W-1:0] idxReg,
  output logic              autoInc
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] FORCE_ONE = DATA_W'(1) << (DATA_W - 2);

  logic [DATA_W-1:0] palMem [DEPTH];
  logic [ADDR_W-1:0] curSlot;

  assign curSlot = idxReg[ADDR_W-1:0];
  assign autoInc = idxReg[DATA_W-1];

  // Index register: load on index write, advance after an auto data write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
    end else if (ctrl.idxWr) begin
      idxReg <= wrData;
    end else if (ctrl.bump) begin
      idxReg[ADDR_W-1:0] <= curSlot + 1'b1;
    end
  end

  // One register per palette slot.
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        palMem[g] <= '0;
      end else if (ctrl.dataWr && (curSlot == ADDR_W'(g))) begin
        palMem[g] <= wrData;
      end
    end
  end

  // Change notification.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chgValid <= 1'b0;
      chgIndex <= '0;
    end else begin
      chgValid <= ctrl.dataWr;
      if (ctrl.dataWr) begin
        chgIndex <= curSlot;
      end
    end
  end

  always_comb begin
    if (ctrl.rdBlank) begin
      cpuRdData = '1;
    end else if (ctrl.rdData) begin
      cpuRdData = palMem[curSlot];
    end else begin
      cpuRdData = idxReg | FORCE_ONE;
    end
  end

  assign pixData = palMem[pixIndex];

endmodule

// File: rtl/pal_port.sv
module pal_port
  import pal_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colorEn,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              chgValid,
  output logic [ADDR_W-1:0] chgIndex,
  input  logic [ADDR_W-1:0] pixIndex,
  output logic [DATA_W-1:0] pixData
);

  palCtrl_t          ctrl;
  logic              autoInc;
  logic [DATA_W-1:0] idxReg;

  pal_port_ctrl u_ctrl (
    .colorEn (colorEn),
    .wrEn    (wrEn),
    .regSel  (regSel),
    .autoInc (autoInc),
    .ctrl    (ctrl)
  );

  pal_port_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wrData    (wrData),
    .pixIndex  (pixIndex),
    .cpuRdData (cpuRdData),
    .chgValid  (chgValid),
    .chgIndex  (chgIndex),
    .pixData   (pixData),
    .idxReg    (idxReg),
    .autoInc   (autoInc)
  );

endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              colorEn,
  input logic              regSel,
  input logic              wrEn,
  input logic [DATA_W-1:0] cpuRdData,
  input logic              chgValid,
  input logic [ADDR_W-1:0] chgIndex,
  input logic [DATA_W-1:0] idxReg
);

  logic dataWrite;
  assign dataWrite = colorEn && wrEn && regSel;

  // R4: a data write is followed by a notification carrying the old slot
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> chgValid);
  a_r4_index: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> chgIndex == $past(idxReg[ADDR_W-1:0]));
  // R8: no notification without an enabled data write
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrite |=> !chgValid);
  // R5 / R7: auto-advance by one, modulo the slot count, flag kept
  a_r5_bump: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && idxReg[DATA_W-1]) |=>
      (idxReg[ADDR_W-1:0] == ADDR_W'($past(idxReg[ADDR_W-1:0]) + 1'b1)) && idxReg[DATA_W-1]);
  // R6: no advance when the flag is clear
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && !idxReg[DATA_W-1]) |=> $stable(idxReg));
  // R8: disabled port ignores writes and reads blank
  a_r8_ignore: assert property (@(posedge clk) disable iff (!rstN)
    !colorEn |=> $stable(idxReg));
  a_r8_blank: assert property (@(posedge clk) disable iff (!rstN)
    !colorEn |-> cpuRdData == '1);
  // R2: bit 6 of the index read is always one
  a_r2_bit6: assert property (@(posedge clk) disable iff (!rstN)
    (colorEn && !regSel) |-> cpuRdData[DATA_W-2]);

endmodule

bind pal_port pal_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .colorEn   (colorEn),
  .regSel    (regSel),
  .wrEn      (wrEn),
  .cpuRdData (cpuRdData),
  .chgValid  (chgValid),
  .chgIndex  (chgIndex),
  .idxReg    (idxReg)
);

// File: tb/test_pal_port.sv
`timescale 1ns/1ps
module test_pal_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       colorEn = 1'b1;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] cpuRdData;
  logic       chgValid;
  logic [5:0] chgIndex;
  logic [5:0] pixIndex = '0;
  logic [7:0] pixData;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] model [64];
  logic [7:0] expIdx;

  always #5 clk = ~clk;

  pal_port i_pal_port (
    .clk(clk), .rstN(rstN), .colorEn(colorEn), .regSel(regSel), .wrEn(wrEn),
    .wrData(wrData), .cpuRdData(cpuRdData), .chgValid(chgValid),
    .chgIndex(chgIndex), .pixIndex(pixIndex), .pixData(pixData)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Write; returns at the next falling edge, where the strobe is visible.
  task automatic doWrite(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regSel = sel; wrData = val; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic sel, output logic [7:0] v);
    regSel = sel;
    #1;
    v = cpuRdData;
  endtask

  initial begin
    #2_000_000;
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    foreach (model[k]) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdReg(1'b0, v); chk("R1 index after reset", v, 8'h40);
    chk("R1 chgValid after reset", {7'd0, chgValid}, 8'h00);

    // R2: every index value reads back with bit 6 set
    for (int i = 0; i < 256; i++) begin
      doWrite(1'b0, 8'(i));
      rdReg(1'b0, v); chk("R2 index readback", v, 8'(i) | 8'h40);
    end

    // R3/R4/R6: manual-index writes to every slot
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 5) & 255);
      doWrite(1'b0, 8'(i));
      doWrite(1'b1, d);
      model[i] = d;
      chk("R4 chgValid pulse", {7'd0, chgValid}, 8'h01);
      chk("R4 chgIndex", {2'b00, chgIndex}, 8'(i));
      rdReg(1'b0, v); chk("R6 index held", v, 8'(i) | 8'h40);
      @(negedge clk);
      chk("R4 pulse one cycle", {7'd0, chgValid}, 8'h00);
    end
    for (int i = 63; i >= 0; i--) begin
      doWrite(1'b0, 8'(i));
      rdReg(1'b1, v); chk("R3 data readback", v, model[i]);
    end

    // R5/R7: auto-advance across the top of the palette
    expIdx = 8'h80 | 8'd60;
    doWrite(1'b0, expIdx);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = 8'(8'hA0 + k);
      doWrite(1'b1, d);
      model[expIdx[5:0]] = d;
      chk("R4 chgIndex auto", {2'b00, chgIndex}, {2'b00, expIdx[5:0]});
      expIdx = {expIdx[7:6], 6'(expIdx[5:0] + 1)};
      rdReg(1'b0, v); chk("R5 R7 index advance", v, expIdx | 8'h40);
    end
    // R7: index 0x7F with flag set also keeps bit 6 stored as one
    doWrite(1'b0, 8'hFF);
    doWrite(1'b1, 8'h5A); model[63] = 8'h5A;
    rdReg(1'b0, v); chk("R7 wrap keeps high bits", v, 8'hC0);

    // R9: renderer port sweep, index untouched
    doWrite(1'b0, 8'h15);
    for (int i = 0; i < 64; i++) begin
      pixIndex = 6'(i);
      #1;
      chk("R9 pixData", pixData, model[i]);
    end
    @(negedge clk);
    rdReg(1'b0, v); chk("R9 index undisturbed", v, 8'h55);

    // R8: disabled port
    colorEn = 1'b0;
    rdReg(1'b0, v); chk("R8 index read blank", v, 8'hFF);
    rdReg(1'b1, v); chk("R8 data read blank", v, 8'hFF);
    doWrite(1'b1, 8'hEE);
    chk("R8 no notify", {7'd0, chgValid}, 8'h00);
    doWrite(1'b0, 8'h02);
    colorEn = 1'b1;
    rdReg(1'b0, v); chk("R8 index unchanged", v, 8'h55);
    rdReg(1'b1, v); chk("R8 slot unchanged", v, model[21]);
    doWrite(1'b0, 8'h02);
    rdReg(1'b1, v); chk("R8 other slot unchanged", v, model[2]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule